// File: doc/BRIEF.md
# I2C Bit-Rate Tick Generator

This block derives the half-period timing for an I2C master's serial clock from a fast system clock. The input clock first passes through a predivider whose ratio (32, 16, 8 or 4) is chosen by a two-bit code. The predivided rate is then divided by a main ratio of BRG + 3 + 2·filter, where BRG is an 8-bit divider value and filter is a single configuration bit. Each time the main division completes, the block emits a single-cycle tick. The bit engine that drives SCL spends one tick in the low phase and one tick in the high phase, so the serial clock runs at half the tick rate.

Configuration arrives on two plain inputs. A 4-bit mode word carries the enable, the predivider code and the filter flag. An 8-bit word carries the divider value. Software picks the values that best match a target bus speed. While the generator is running, it samples new values only when a tick is emitted, so a rate change never produces a shortened half-period. Clearing the enable stops the generator at once and throws away any partial count.

Top module: `i2c_bitclk_gen`

## Requirements
- R1: Bit 0 of the mode word is the enable. While it is 0, no tick is produced and both internal counters are held at zero.
- R2: Bits 2:1 of the mode word hold the predivider code. Codes 0, 1, 2 and 3 give predivider ratios P of 32, 16, 8 and 4, which is 32 >> code.
- R3: Bit 3 of the mode word is the filter flag. The main ratio is M = BRG + 3 + 2·filter, where BRG is the unsigned 8-bit divider value (0 to 255).
- R4: While enabled, ticks are spaced exactly P·M input clock cycles apart. Each tick is high for exactly one cycle, so the SCL period is 2·P·M cycles.
- R5: Call the first rising clock edge that samples the enable at 1 edge 1. The first tick goes high just after enabled edge number P·M. It uses the divider, code and filter values that were present at edge 1.
- R6: Changes to the divider value, the predivider code or the filter flag while the generator is running do not affect the interval in progress. They are applied from the tick that ends that interval onward.
- R7: An active-low asynchronous reset clears the counters and the tick output. After reset is released with the enable set, the first tick arrives as in R5.
- R8: Clearing the enable in the middle of an interval discards the partial count. Setting it again starts a full interval as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeReg | input | 4 | Mode word: bit 0 enable, bits 2:1 predivider code, bit 3 filter flag |
| divReg | input | DIV_W (8) | Main divider value BRG |
| bitTick | output | 1 | One-cycle tick at twice the SCL rate |

## Verification
The tick is registered, so it appears in the cycle after the clock edge that completes the count. The bench counts rising edges from the first edge that samples the enable, and checks the tick level at the following falling edge. Under that rule, both the latency of the first tick and every later interval must equal P·M edges exactly.

A stuck or doubled tick is seen as an interval of one edge. Rate changes are applied on a falling edge either just after a tick or partway through an interval. The bench then expects the old spacing once and the new spacing on the next interval. Checks for reset and for a stopped generator sample the tick at falling edges, while reset is held or while the enable is low.

// File: rtl/i2c_bitclk_pkg.sv
package i2c_bitclk_pkg;

  // Mode word field positions (decoded by the control and datapath)
  localparam int MODE_EN_BIT   = 0;
  localparam int MODE_CODE_LSB = 1;
  localparam int MODE_FILT_BIT = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;   // generator stopped: hold counters at zero
    logic step;  // one predivided period has elapsed
    logic load;  // boundary: capture new configuration
  } bitclkStrobe_t;

endpackage

// File: rtl/i2c_bitclk_ctrl.sv
module i2c_bitclk_ctrl
  import i2c_bitclk_pkg::*;
#(
  parameter int PRE_CODE_W    = 2,
  parameter int MAX_PRE_SHIFT = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enIn,
  input  logic [PRE_CODE_W-1:0] codeIn,
  input  logic                  atTerm,
  output bitclkStrobe_t         strb
);

  localparam int NUM_CODES = 1 << PRE_CODE_W;
  localparam int PRE_W     = MAX_PRE_SHIFT;

  logic [PRE_W-1:0]      limTab [NUM_CODES];
  logic [PRE_W-1:0]      preCnt;
  logic [PRE_CODE_W-1:0] codeSh;
  logic                  running;
  logic                  preWrap;

  // Terminal count of the predivider for each code: (2^(MAX-code)) - 1
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
    assign limTab[g] = PRE_W'((1 << (MAX_PRE_SHIFT - g)) - 1);
  end

  assign preWrap = (preCnt == limTab[codeSh]);

  always_comb begin
    strb.clr  = ~enIn;
    strb.step = enIn & running & preWrap;
    strb.load = enIn & (~running | (strb.step & atTerm));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else begin
      running <= enIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!enIn) begin
      preCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeSh <= '0;
    end else if (strb.load) begin
      codeSh <= codeIn;
    end
  end

  // R2: the predivider never runs past the limit of the captured code
  a_r2_pre_bound : assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= limTab[codeSh]);

  // R1: a stopped generator holds the predivider at zero
  a_r1_stop_clears_pre : assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> (preCnt == '0));

endmodule

// File: rtl/i2c_bitclk_dpath.sv
module i2c_bitclk_dpath
  import i2c_bitclk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int BASE_OFFSET = 3,
  parameter int FILTER_TERM = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  bitclkStrobe_t    strb,
  input  logic [DIV_W-1:0] divIn,
  input  logic             filtIn,
  output logic             atTerm,
  output logic             tickOut
);

  localparam int CNT_W = $clog2((1 << DIV_W) + BASE_OFFSET + FILTER_TERM);

  logic [DIV_W-1:0] divSh;
  logic             filtSh;
  logic [CNT_W-1:0] mainCnt;
  logic [CNT_W-1:0] termVal;
  logic             tickQ;

  // Last count value of an interval: BRG + OFFSET - 1 (+ filter term)
  always_comb begin
    termVal = CNT_W'(divSh) + CNT_W'(BASE_OFFSET - 1)
            + (filtSh ? CNT_W'(FILTER_TERM) : CNT_W'(0));
  end

  assign atTerm = (mainCnt == termVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSh  <= '0;
      filtSh <= 1'b0;
    end else if (strb.load) begin
      divSh  <= divIn;
      filtSh <= filtIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt <= '0;
    end else if (strb.clr) begin
      mainCnt <= '0;
    end else if (strb.step) begin
      mainCnt <= atTerm ? '0 : mainCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ <= 1'b0;
    end else begin
      tickQ <= strb.step & atTerm & ~strb.clr;
    end
  end

  assign tickOut = tickQ;

  // R4: a tick never lasts more than one cycle
  a_r4_single_cycle_tick : assert property (@(posedge clk) disable iff (!rstN)
    tickQ |=> !tickQ);

  // R3: the main counter stays within the captured ratio
  a_r3_main_bound : assert property (@(posedge clk) disable iff (!rstN)
    mainCnt <= termVal);

  // R1: stopping clears the main counter
  a_r1_stop_clears_main : assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (mainCnt == '0));

endmodule

// File: rtl/i2c_bitclk_gen.sv
module i2c_bitclk_gen
  import i2c_bitclk_pkg::*;
#(
  parameter int DIV_W         = 8,
  parameter int PRE_CODE_W    = 2,
  parameter int MAX_PRE_SHIFT = 5,
  parameter int BASE_OFFSET   = 3,
  parameter int FILTER_TERM   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       modeReg,
  input  logic [DIV_W-1:0] divReg,
  output logic             bitTick
);

  bitclkStrobe_t         strb;
  logic                  atTerm;
  logic                  enBit;
  logic                  filtBit;
  logic [PRE_CODE_W-1:0] codeBits;

  assign enBit    = modeReg[MODE_EN_BIT];
  assign filtBit  = modeReg[MODE_FILT_BIT];
  assign codeBits = modeReg[MODE_CODE_LSB +: PRE_CODE_W];

  i2c_bitclk_ctrl #(
    .PRE_CODE_W   (PRE_CODE_W),
    .MAX_PRE_SHIFT(MAX_PRE_SHIFT)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .enIn  (enBit),
    .codeIn(codeBits),
    .atTerm(atTerm),
    .strb  (strb)
  );

  i2c_bitclk_dpath #(
    .DIV_W      (DIV_W),
    .BASE_OFFSET(BASE_OFFSET),
    .FILTER_TERM(FILTER_TERM)
  ) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .divIn  (divReg),
    .filtIn (filtBit),
    .atTerm (atTerm),
    .tickOut(bitTick)
  );

  // R1: with the enable low, the next cycle carries no tick
  a_r1_off_no_tick : assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> !bitTick);

endmodule

// File: tb/i2c_bitclk_gen_tb_top.sv
module i2c_bitclk_gen_tb_top;

  localparam int WAIT_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] modeReg;
  logic [7:0] divReg;
  logic       bitTick;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_bitclk_gen dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .modeReg(modeReg),
    .divReg (divReg),
    .bitTick(bitTick)
  );

  // {code[1:0], filter, brg[7:0]}
  localparam logic [10:0] VEC [16] = '{
    {2'd0, 1'b0, 8'd0}, {2'd0, 1'b0, 8'd255}, {2'd0, 1'b1, 8'd0}, {2'd0, 1'b1, 8'd255},
    {2'd1, 1'b0, 8'd0}, {2'd1, 1'b0, 8'd255}, {2'd1, 1'b1, 8'd0}, {2'd1, 1'b1, 8'd255},
    {2'd2, 1'b0, 8'd0}, {2'd2, 1'b0, 8'd255}, {2'd2, 1'b1, 8'd0}, {2'd2, 1'b1, 8'd255},
    {2'd3, 1'b0, 8'd0}, {2'd3, 1'b0, 8'd255}, {2'd3, 1'b1, 8'd0}, {2'd3, 1'b1, 8'd255}
  };

  function automatic int span(input int code, input int filt, input int brg);
    return (32 >> code) * (brg + 3 + 2 * filt);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Counts rising edges until the tick is seen at a falling edge
  task automatic countToTick(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!bitTick && n < WAIT_LIMIT);
  endtask

  task automatic setCfg(input int code, input int filt, input int brg, input bit en);
    modeReg = {filt[0], code[1:0], en};
    divReg  = brg[7:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R4 watchdog: cycles=%0d expected below %0d", 190000, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int n;
    int ticks;
    rstN = 1'b0;
    setCfg(3, 0, 0, 1'b1);

    // R7: tick low while reset is held
    repeat (3) begin
      @(negedge clk);
      check(bitTick == 1'b0, "R7 tick during reset", bitTick, 0);
    end
    rstN = 1'b1;
    countToTick(n);
    check(n == span(3, 0, 0), "R7 first tick after reset", n, span(3, 0, 0));
    @(posedge clk); @(negedge clk);
    check(bitTick == 1'b0, "R4 tick one cycle wide", bitTick, 0);

    // Vector table: R2, R3, R4, R5 across codes, filter, BRG extremes
    for (int v = 0; v < 16; v++) begin
      int code, filt, brg, exp;
      code = int'(VEC[v][10:9]);
      filt = int'(VEC[v][8]);
      brg  = int'(VEC[v][7:0]);
      exp  = span(code, filt, brg);
      setCfg(0, 0, 0, 1'b0);
      @(posedge clk); @(negedge clk);
      setCfg(code, filt, brg, 1'b1);
      countToTick(n);
      check(n == exp, $sformatf("R5/R2/R3 first tick vec %0d", v), n, exp);
      countToTick(n);
      check(n == exp, $sformatf("R4/R2/R3 interval vec %0d", v), n, exp);
    end

    // R6: change right after a tick
    setCfg(0, 0, 0, 1'b0);
    @(posedge clk); @(negedge clk);
    setCfg(3, 0, 5, 1'b1);
    countToTick(n);
    setCfg(2, 0, 10, 1'b1);
    countToTick(n);
    check(n == span(3, 0, 5), "R6 old interval kept", n, span(3, 0, 5));
    countToTick(n);
    check(n == span(2, 0, 10), "R6 new interval applied", n, span(2, 0, 10));

    // R6: change in the middle of an interval
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 7) setCfg(3, 1, 0, 1'b1);
    end while (!bitTick && n < WAIT_LIMIT);
    check(n == span(2, 0, 10), "R6 mid change deferred", n, span(2, 0, 10));
    countToTick(n);
    check(n == span(3, 1, 0), "R6 mid change applied", n, span(3, 1, 0));

    // R1: stopped generator gives no ticks
    setCfg(3, 0, 0, 1'b0);
    ticks = 0;
    repeat (300) begin
      @(posedge clk); @(negedge clk);
      if (bitTick) ticks++;
    end
    check(ticks == 0, "R1 no tick while disabled", ticks, 0);

    // R8: disable mid-interval, re-enable restarts a full interval
    setCfg(3, 0, 0, 1'b1);
    countToTick(n);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    setCfg(3, 0, 0, 1'b0);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check(bitTick == 1'b0, "R1 tick low after stop", bitTick, 0);
    setCfg(3, 0, 0, 1'b1);
    countToTick(n);
    check(n == span(3, 0, 0), "R8 full interval after re-enable", n, span(3, 0, 0));

    // R7: reset in the middle of an interval
    setCfg(2, 1, 3, 1'b1);
    countToTick(n);
    repeat (9) begin @(posedge clk); @(negedge clk); end
    rstN = 1'b0;
    @(negedge clk);
    check(bitTick == 1'b0, "R7 tick cleared by reset", bitTick, 0);
    rstN = 1'b1;
    countToTick(n);
    check(n == span(2, 1, 3), "R7 restart after mid reset", n, span(2, 1, 3));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule